// File: doc/BRIEF.md
# Shift-Compare Execute Unit with Byte Immediate Merge

This block is the combinational execute stage of a small 16-bit processor. The decoder gives it a 5-bit operation code and the values it needs: the two source registers, the current value of the destination register, an 8-bit immediate field and the address of the current instruction. In the same cycle it returns the word to write back to the register file. The operations are add and subtract, three shifts, three bitwise logic functions, five comparisons, add-immediate, upper-byte load, lower-byte merge and link-address generation.

Comparisons do not set flags. Each one writes 0 or 1 as an ordinary register value, so a branch that follows can test any register. The lower-byte merge keeps the upper half of the destination register, so the destination is read as a third source operand. The block also gives the target address of the register-indirect jump as a separate output. Branch resolution, program-counter update, control registers and memory access are handled elsewhere.

Top module: `shiftcmp_alu`

## Requirements
- R1: With code 0x00 the result is src_a + src_b, and with code 0x01 it is src_a - src_b. Both wrap modulo 2^16.
- R2: Code 0x02 shifts src_a left by the amount held in src_b[3:0] and fills with zeros. Bits src_b[15:4] do not change the result.
- R3: Code 0x03 shifts src_a right by src_b[3:0] and fills with zeros. Code 0x04 shifts right by the same amount and fills with copies of src_a[15].
- R4: Codes 0x10, 0x11 and 0x12 give the bitwise AND, OR and XOR of src_a and src_b.
- R5: Code 0x13 tests src_a == src_b. Code 0x14 tests src_a > src_b and code 0x15 tests src_a >= src_b, both as two's-complement values. The result is 0x0001 when the test holds and 0x0000 when it does not.
- R6: Code 0x16 tests src_a > src_b and code 0x17 tests src_a >= src_b, both as unsigned values. The result is 0x0001 or 0x0000.
- R7: Code 0x05 adds imm[4:0], sign-extended from bit 4, to src_a with wraparound. Bits imm[7:5] do not change the result.
- R8: Code 0x06 gives imm in the upper byte of the result and 0x00 in the lower byte.
- R9: Code 0x07 gives cur_dst[15:8] in the upper byte of the result and imm in the lower byte.
- R10: Code 0x18 gives pc + 2 as the result, with wraparound. For every code, jump_target is src_a + src_b modulo 2^16, which is the same as adding src_b as a signed offset.
- R11: Every code not listed above (0x08 to 0x0F and 0x19 to 0x1F) gives a result of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Decoded operation code |
| src_a | input | 16 | First source register value |
| src_b | input | 16 | Second source register value, or the shift amount |
| cur_dst | input | 16 | Current value of the destination register |
| imm | input | 8 | Immediate field. Bits [4:0] are used by add-immediate. |
| pc | input | 16 | Address of the current instruction |
| result | output | 16 | Value to write back |
| jump_target | output | 16 | Target address of the register-indirect jump |

## Verification
The immediate assertions check, whenever the inputs change, the properties that can be seen from the output alone:
- add and subtract can be inverted back to src_a;
- a logical right shift by a nonzero amount clears the top bit;
- an arithmetic right shift keeps the sign;
- a comparison never sets any bit above bit 0;
- upper-byte load clears the low byte;
- the merge keeps the upper byte of cur_dst;
- the link value is exactly two above pc.

Other behaviour can only be shown by the bench's scenarios, which compare against a model:
- the exact shift amounts, and that src_b[15:4] are ignored;
- signed and unsigned ordering at 0x7FFF and 0x8000;
- sign extension of the 5-bit immediate;
- zero results for the unused codes.

// File: rtl/shiftcmp_alu.sv
module shiftcmp_alu #(
  parameter int W = 16,
  parameter int SIMM_W = 5
) (
  input  logic [4:0]     op,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [W-1:0]   cur_dst,
  input  logic [W/2-1:0] imm,
  input  logic [W-1:0]   pc,
  output logic [W-1:0]   result,
  output logic [W-1:0]   jump_target
);
  localparam int HALF = W / 2;
  localparam int SH_W = $clog2(W);

  localparam logic [4:0] C_ADD  = 5'h00;
  localparam logic [4:0] C_SUB  = 5'h01;
  localparam logic [4:0] C_SHL  = 5'h02;
  localparam logic [4:0] C_SHRL = 5'h03;
  localparam logic [4:0] C_SHRA = 5'h04;
  localparam logic [4:0] C_ADDI = 5'h05;
  localparam logic [4:0] C_HIGH = 5'h06;
  localparam logic [4:0] C_LOWM = 5'h07;
  localparam logic [4:0] C_AND  = 5'h10;
  localparam logic [4:0] C_OR   = 5'h11;
  localparam logic [4:0] C_XOR  = 5'h12;
  localparam logic [4:0] C_EQ   = 5'h13;
  localparam logic [4:0] C_SGT  = 5'h14;
  localparam logic [4:0] C_SGE  = 5'h15;
  localparam logic [4:0] C_UGT  = 5'h16;
  localparam logic [4:0] C_UGE  = 5'h17;
  localparam logic [4:0] C_LINK = 5'h18;

  logic [SH_W-1:0] amt;
  logic [W-1:0]    simm;
  logic            flag;
  logic            is_cmp;

  assign amt  = src_b[SH_W-1:0];
  assign simm = {{(W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
  assign jump_target = src_a + src_b;

  always_comb begin
    is_cmp = 1'b1;
    unique case (op)
      C_EQ:    flag = (src_a == src_b);
      C_SGT:   flag = ($signed(src_a) >  $signed(src_b));
      C_SGE:   flag = ($signed(src_a) >= $signed(src_b));
      C_UGT:   flag = (src_a >  src_b);
      C_UGE:   flag = (src_a >= src_b);
      default: begin flag = 1'b0; is_cmp = 1'b0; end
    endcase
  end

  always_comb begin
    case (op)
      C_ADD:   result = src_a + src_b;
      C_SUB:   result = src_a - src_b;
      C_SHL:   result = src_a << amt;
      C_SHRL:  result = src_a >> amt;
      C_SHRA:  result = W'($signed(src_a) >>> amt);
      C_ADDI:  result = src_a + simm;
      C_HIGH:  result = {imm, {HALF{1'b0}}};
      C_LOWM:  result = {cur_dst[W-1:HALF], imm};
      C_AND:   result = src_a & src_b;
      C_OR:    result = src_a | src_b;
      C_XOR:   result = src_a ^ src_b;
      C_LINK:  result = pc + W'(2);
      default: result = is_cmp ? {{(W-1){1'b0}}, flag} : '0;
    endcase
  end

  always_comb begin
    if (op == C_ADD)
      AST_ADD_UNDO: assert (W'(result - src_b) == src_a) else $error("add undo"); // R1
    if (op == C_SUB)
      AST_SUB_UNDO: assert (W'(result + src_b) == src_a) else $error("sub undo"); // R1
    if (op == C_SHRL && amt != '0)
      AST_SHRL_TOP_CLEAR: assert (!result[W-1]) else $error("shrl top"); // R3
    if (op == C_SHRA)
      AST_SHRA_SIGN_KEPT: assert (result[W-1] == src_a[W-1]) else $error("shra sign"); // R3
    if (op >= C_EQ && op <= C_UGE)
      AST_CMP_BOOLEAN: assert (result[W-1:1] == '0) else $error("cmp bool"); // R5
    if (op == C_HIGH)
      AST_HIGH_LOW_ZERO: assert (result[HALF-1:0] == '0) else $error("high low"); // R8
    if (op == C_LOWM)
      AST_LOWM_KEEPS_TOP: assert (result[W-1:HALF] == cur_dst[W-1:HALF]) else $error("lowm top"); // R9
    if (op == C_LINK)
      AST_LINK_STEP: assert (W'(result - pc) == W'(2)) else $error("link step"); // R10
  end
endmodule

// File: tb/tb_shiftcmp_alu.sv
module tb_shiftcmp_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [4:0]  op;
  logic [15:0] a, b, d, pc;
  logic [7:0]  imm;
  logic [15:0] res, tgt;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  shiftcmp_alu dut (.op(op), .src_a(a), .src_b(b), .cur_dst(d), .imm(imm),
                    .pc(pc), .result(res), .jump_target(tgt));

  function automatic int sgn(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic int model(int o, int x, int y, int c, int i, int p);
    int sh = y & 15;
    int sx = sgn(x, 16), sy = sgn(y, 16);
    case (o)
      'h00: return (x + y) & 'hFFFF;
      'h01: return (x - y) & 'hFFFF;
      'h02: return (x << sh) & 'hFFFF;
      'h03: return x >> sh;
      'h04: return (sx >>> sh) & 'hFFFF;
      'h05: return (x + sgn(i & 31, 5)) & 'hFFFF;
      'h06: return (i & 'hFF) * 256;
      'h07: return (c & 'hFF00) | (i & 'hFF);
      'h10: return x & y;
      'h11: return x | y;
      'h12: return x ^ y;
      'h13: return (x == y) ? 1 : 0;
      'h14: return (sx > sy) ? 1 : 0;
      'h15: return (sx >= sy) ? 1 : 0;
      'h16: return (x > y) ? 1 : 0;
      'h17: return (x >= y) ? 1 : 0;
      'h18: return (p + 2) & 'hFFFF;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int o);
    case (o)
      'h00, 'h01: return "R1";
      'h02: return "R2";
      'h03, 'h04: return "R3";
      'h05: return "R7";
      'h06: return "R8";
      'h07: return "R9";
      'h10, 'h11, 'h12: return "R4";
      'h13, 'h14, 'h15: return "R5";
      'h16, 'h17: return "R6";
      'h18: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s op=%02h a=%04h b=%04h d=%04h imm=%02h pc=%04h actual=%04h expected=%04h",
               req, op, a, b, d, imm, pc, got, exp);
    end
  endtask

  task automatic apply(int o, int x, int y, int c, int i, int p);
    @(posedge clk);
    #1;
    op = 5'(o); a = 16'(x); b = 16'(y); d = 16'(c); imm = 8'(i); pc = 16'(p);
    @(negedge clk);
    check(req_of(o), int'(res), model(o, x, y, c, i, p));
    check("R10", int'(tgt), (x + y) & 'hFFFF);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  int ops[17] = '{'h00, 'h01, 'h02, 'h03, 'h04, 'h05, 'h06, 'h07,
                  'h10, 'h11, 'h12, 'h13, 'h14, 'h15, 'h16, 'h17, 'h18};
  int bnd[4]  = '{'h0000, 'h7FFF, 'h8000, 'hFFFF};
  int imms[4] = '{'h00, 'h1F, 'h10, 'hFF};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op = '0; a = '0; b = '0; d = '0; imm = '0; pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", int'(res), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 17; k++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply(ops[k], bnd[i], bnd[j], bnd[(i + j) % 4], imms[j], bnd[i]);

    apply('h02, 'h0001, 'h0011, 0, 0, 0);   // R2 upper shift bits ignored
    apply('h02, 'h8001, 'hFFF0, 0, 0, 0);   // R2 amount 0
    apply('h03, 'h8000, 'h000F, 0, 0, 0);   // R3 logical full shift
    apply('h04, 'h8000, 'h000F, 0, 0, 0);   // R3 arithmetic full shift
    apply('h05, 'h0010, 0, 0, 'hE3, 0);     // R7 high imm bits ignored
    apply('h05, 'h0000, 0, 0, 'h10, 0);     // R7 most negative imm5
    apply('h14, 'h7FFF, 'h8000, 0, 0, 0);   // R5 signed order
    apply('h16, 'h7FFF, 'h8000, 0, 0, 0);   // R6 unsigned order
    apply('h15, 'h1234, 'h1234, 0, 0, 0);   // R5 equal ge
    apply('h17, 'h1234, 'h1234, 0, 0, 0);   // R6 equal ge
    apply('h07, 0, 0, 'hABCD, 'h42, 0);     // R9 merge
    apply('h18, 0, 0, 0, 0, 'hFFFE);        // R10 link wraps

    for (int k = 0; k < 17; k++)
      for (int r = 0; r < 100; r++)
        apply(ops[k], int'($urandom & 'hFFFF), int'($urandom & 'hFFFF),
              int'($urandom & 'hFFFF), int'($urandom & 'hFF), int'($urandom & 'hFFFF));

    for (int o = 'h08; o < 'h20; o++) begin
      if (o >= 'h10 && o <= 'h18) continue;
      for (int r = 0; r < 20; r++)
        apply(o, int'($urandom & 'hFFFF), int'($urandom & 'hFFFF),
              int'($urandom & 'hFFFF), int'($urandom & 'hFF), int'($urandom & 'hFFFF)); // R11
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule